// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block captures interrupt requests for one eight-line interrupt controller. Every request line is sampled on each clock. A per-line trigger-mode bit decides how the sample becomes a pending request. In level mode the pending bit simply follows the line. In edge mode a low-to-high transition between two consecutive samples sets the pending bit, and the bit then stays set until the acknowledge logic clears it.

The pending vector is presented to downstream priority logic together with a per-line flag. That flag shows which pending requests are currently masked by an externally held mask vector. The mask never prevents a request from being recorded.

The trigger-mode register is loaded by a write strobe carrying a full byte. A per-instance writable-bit parameter forces chosen lines to stay in edge mode whatever is written. An initialization input clears the pending state and the remembered line levels without touching the trigger modes.

Top module: `irq_req_latch`

## Requirements
- R1: After synchronous reset, `pending`, `masked` and `trig_mode` are all zero, so every line starts in edge mode.
- R2: With `trig_wr_en` high at a clock edge, `trig_mode` takes `trig_wr_data & WRITE_MASK` from that edge on. A 1 in a bit selects level mode and a 0 selects edge mode. Bits outside `WRITE_MASK` always read 0. Without the strobe, `trig_mode` holds its value.
- R3: For a level-mode line, the pending bit equals the line as sampled at the previous clock edge. `ack_clr` has no effect on it.
- R4: For an edge-mode line, the pending bit is set at the edge where the sample is 1 and the previous sample was 0. A line held high after a clear does not set the bit again.
- R5: An edge-mode pending bit stays set after its line falls, until `ack_clr` or `init_clr` clears it.
- R6: An `ack_clr` bit clears the matching edge-mode pending bit at the next edge.
- R7: When `ack_clr` and a new rising edge hit the same edge-mode line in the same cycle, the pending bit stays set.
- R8: `masked` equals `pending & mask_in`, with the mask sampled at the same edge that produced `pending`. A masked line is still latched into `pending`.
- R9: `init_clr` clears `pending`, `masked` and the remembered line levels at the next edge, and leaves `trig_mode` unchanged. An edge-mode line held high across initialization is therefore latched again at the first edge after `init_clr` drops.
- R10: Switching a line that is high from level mode to edge mode does not create a new request. After the bit carried over from level mode is cleared, the line stays not pending while it remains high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_clr | input | 1 | Initialization: clear pending state and remembered levels |
| irq_in | input | N_LINES | Request lines, sampled every clock |
| mask_in | input | N_LINES | Current mask vector, 1 = masked |
| ack_clr | input | N_LINES | Per-line clear from the acknowledge logic |
| trig_wr_en | input | 1 | Write strobe for the trigger-mode register |
| trig_wr_data | input | N_LINES | Data written to the trigger-mode register |
| pending | output | N_LINES | Registered pending request vector |
| masked | output | N_LINES | Registered per-line masked-and-pending flag |
| trig_mode | output | N_LINES | Trigger-mode register, 1 = level, 0 = edge |

## Verification
The collision that matters is an acknowledge clear arriving in the same cycle as a fresh rising edge on the same edge-mode line. The stimulus table arranges this by dropping the line for one cycle and then raising it while `ack_clr` targets that line. The pending bit must read 1 afterwards. The next vector keeps the line high and clears again, and the bit must then read 0, which shows that the earlier survival came from the edge and not from an ignored clear. A second overlap, a trigger-mode write landing while a level line is high, is judged by the pending bit holding through the switch and staying low after a later clear.

// File: rtl/irl_pkg.sv
package irl_pkg;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;

  // Next pending value of one line; a fresh rising edge beats a clear.
  function automatic logic irl_next_pend(input trig_e mode, input logic line,
                                         input logic prev, input logic held,
                                         input logic clr);
    logic rise;
    rise = line & ~prev;
    if (mode == TRIG_LEVEL) return line;
    if (rise)               return 1'b1;
    if (clr)                return 1'b0;
    return held;
  endfunction

endpackage

// File: rtl/irl_trig_reg.sv
module irl_trig_reg #(
  parameter int                 N_LINES    = 8,
  parameter logic [N_LINES-1:0] WRITE_MASK = 8'hF8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [N_LINES-1:0] wr_data,
  output logic [N_LINES-1:0] mode_o
);

  logic [N_LINES-1:0] mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
    end else if (wr_en) begin
      mode_q <= wr_data & WRITE_MASK;
    end
  end

  assign mode_o = mode_q;

endmodule

// File: rtl/irl_line_cell.sv
module irl_line_cell
  import irl_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  init_clr,
  input  trig_e mode_i,
  input  logic  line_i,
  input  logic  clr_i,
  input  logic  mask_i,
  output logic  pend_o,
  output logic  masked_o
);

  logic prev_q;
  logic pend_q;
  logic masked_q;
  logic pend_d;

  always_comb begin
    pend_d = irl_next_pend(mode_i, line_i, prev_q, pend_q, clr_i);
  end

  always_ff @(posedge clk) begin
    if (rst || init_clr) begin
      prev_q   <= 1'b0;
      pend_q   <= 1'b0;
      masked_q <= 1'b0;
    end else begin
      prev_q   <= line_i;
      pend_q   <= pend_d;
      masked_q <= pend_d & mask_i;
    end
  end

  assign pend_o   = pend_q;
  assign masked_o = masked_q;

endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
  import irl_pkg::*;
#(
  parameter int                 N_LINES    = 8,
  parameter logic [N_LINES-1:0] WRITE_MASK = 8'hF8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               init_clr,
  input  logic [N_LINES-1:0] irq_in,
  input  logic [N_LINES-1:0] mask_in,
  input  logic [N_LINES-1:0] ack_clr,
  input  logic               trig_wr_en,
  input  logic [N_LINES-1:0] trig_wr_data,
  output logic [N_LINES-1:0] pending,
  output logic [N_LINES-1:0] masked,
  output logic [N_LINES-1:0] trig_mode
);

  logic [N_LINES-1:0] mode_w;

  irl_trig_reg #(
    .N_LINES   (N_LINES),
    .WRITE_MASK(WRITE_MASK)
  ) trig_i (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (trig_wr_en),
    .wr_data(trig_wr_data),
    .mode_o (mode_w)
  );

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    irl_line_cell cell_i (
      .clk     (clk),
      .rst     (rst),
      .init_clr(init_clr),
      .mode_i  (trig_e'(mode_w[g])),
      .line_i  (irq_in[g]),
      .clr_i   (ack_clr[g]),
      .mask_i  (mask_in[g]),
      .pend_o  (pending[g]),
      .masked_o(masked[g])
    );
  end

  assign trig_mode = mode_w;

endmodule

// File: rtl/irq_req_latch_chk.sv
module irq_req_latch_chk #(
  parameter int                 N_LINES    = 8,
  parameter logic [N_LINES-1:0] WRITE_MASK = 8'hF8
) (
  input logic               clk,
  input logic               rst,
  input logic               init_clr,
  input logic [N_LINES-1:0] irq_in,
  input logic [N_LINES-1:0] mask_in,
  input logic [N_LINES-1:0] ack_clr,
  input logic               trig_wr_en,
  input logic [N_LINES-1:0] trig_wr_data,
  input logic [N_LINES-1:0] pending,
  input logic [N_LINES-1:0] masked,
  input logic [N_LINES-1:0] trig_mode
);

  logic armed = 1'b0;

  always_ff @(posedge clk) begin
    armed <= !rst;
  end

  // R3
  level_follow_chk: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(init_clr) |-> (($past(trig_mode) & (pending ^ $past(irq_in))) == '0));

  // R5
  edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(init_clr) |->
      ((~$past(trig_mode) & $past(pending) & ~$past(ack_clr) & ~pending) == '0));

  // R8
  masked_flag_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> (masked == (pending & $past(mask_in))));

  // R2
  trig_write_chk: assert property (@(posedge clk) disable iff (rst)
    armed && $past(trig_wr_en) |-> (trig_mode == ($past(trig_wr_data) & WRITE_MASK)));

  // R2
  trig_hold_chk: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(trig_wr_en) |-> $stable(trig_mode));

  // R9
  init_clear_chk: assert property (@(posedge clk) disable iff (rst)
    armed && $past(init_clr) |-> (pending == '0 && masked == '0));

endmodule

bind irq_req_latch irq_req_latch_chk #(
  .N_LINES   (N_LINES),
  .WRITE_MASK(WRITE_MASK)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .init_clr    (init_clr),
  .irq_in      (irq_in),
  .mask_in     (mask_in),
  .ack_clr     (ack_clr),
  .trig_wr_en  (trig_wr_en),
  .trig_wr_data(trig_wr_data),
  .pending     (pending),
  .masked      (masked),
  .trig_mode   (trig_mode)
);

// File: tb/irq_req_latch_tb_top.sv
`timescale 1ns/1ps
module irq_req_latch_tb_top;

  typedef struct packed {
    logic [7:0] irq;
    logic [7:0] msk;
    logic [7:0] clr;
    logic [7:0] exp_p;
    logic [7:0] exp_m;
  } vec_t;

  // Trigger modes 8'hF8: lines 0..2 edge, 3..7 level.
  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
    '{8'h09, 8'h01, 8'h00, 8'h09, 8'h01},  // R4 rise, R3 level
    '{8'h00, 8'h08, 8'h00, 8'h01, 8'h00},  // R5 hold, R3 drop
    '{8'h01, 8'hFF, 8'h01, 8'h01, 8'h01},  // R7 rise beats clear
    '{8'h01, 8'hFF, 8'h01, 8'h00, 8'h00},  // R6 clear, line held
    '{8'h01, 8'hFF, 8'h00, 8'h00, 8'h00},  // R4 held high no reset
    '{8'h86, 8'h04, 8'h80, 8'h86, 8'h04},  // R3 clear ignored on level
    '{8'h00, 8'h00, 8'h02, 8'h04, 8'h00},  // R6 one edge cleared
    '{8'h78, 8'h30, 8'hFF, 8'h78, 8'h30}   // R8 masked still latched
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       init_clr = 1'b0;
  logic [7:0] irq_in = '0, mask_in = '0, ack_clr = '0, wr_data = '0;
  logic       wr_en = 1'b0;
  logic [7:0] pending, masked, trig_mode;
  logic [7:0] s_pending, s_masked, s_trig;
  logic       s_wr_en = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_req_latch #(.N_LINES(8), .WRITE_MASK(8'hF8)) dut_i (
    .clk(clk), .rst(rst), .init_clr(init_clr), .irq_in(irq_in),
    .mask_in(mask_in), .ack_clr(ack_clr), .trig_wr_en(wr_en),
    .trig_wr_data(wr_data), .pending(pending), .masked(masked),
    .trig_mode(trig_mode)
  );

  irq_req_latch #(.N_LINES(8), .WRITE_MASK(8'hDE)) dut_s (
    .clk(clk), .rst(rst), .init_clr(1'b0), .irq_in(8'h00),
    .mask_in(8'h00), .ack_clr(8'h00), .trig_wr_en(s_wr_en),
    .trig_wr_data(8'hFF), .pending(s_pending), .masked(s_masked),
    .trig_mode(s_trig)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [7:0] irq, input logic [7:0] msk, input logic [7:0] clr);
    irq_in  = irq;
    mask_in = msk;
    ack_clr = clr;
    @(posedge clk);
    #1;
  endtask

  task automatic wr_trig(input logic [7:0] d);
    wr_en   = 1'b1;
    wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    // R1
    check("R1 pending", pending, 8'h00);
    check("R1 masked", masked, 8'h00);
    check("R1 trig_mode", trig_mode, 8'h00);

    // R2
    wr_trig(8'hA5);
    check("R2 masked write", trig_mode, 8'hA0);
    cyc(8'h00, 8'h00, 8'h00);
    check("R2 hold without strobe", trig_mode, 8'hA0);
    wr_trig(8'hFF);
    check("R2 write all", trig_mode, 8'hF8);
    s_wr_en = 1'b1;
    @(posedge clk);
    #1;
    s_wr_en = 1'b0;
    check("R2 second instance mask", s_trig, 8'hDE);

    for (int i = 0; i < NV; i++) begin
      cyc(VECS[i].irq, VECS[i].msk, VECS[i].clr);
      check($sformatf("R3/R4/R5/R6/R7 vec%0d pending", i), pending, VECS[i].exp_p);
      check($sformatf("R8 vec%0d masked", i), masked, VECS[i].exp_m);
    end

    // R10: line 3 high in level mode, then switched to edge
    cyc(8'h00, 8'h00, 8'h00);
    cyc(8'h08, 8'h00, 8'h00);
    check("R10 level set", pending, 8'h08);
    irq_in = 8'h08;
    wr_trig(8'hF0);
    check("R10 during switch", pending, 8'h08);
    cyc(8'h08, 8'h00, 8'h00);
    check("R10 carried bit held", pending, 8'h08);
    cyc(8'h08, 8'h00, 8'h08);
    check("R10 cleared", pending, 8'h00);
    cyc(8'h08, 8'h00, 8'h00);
    check("R10 no new request", pending, 8'h00);

    // R9: edge line 0 held high across init
    cyc(8'h00, 8'h00, 8'h00);
    cyc(8'h01, 8'h01, 8'h00);
    check("R9 pre-init set", pending, 8'h01);
    init_clr = 1'b1;
    cyc(8'h01, 8'h01, 8'h00);
    init_clr = 1'b0;
    check("R9 pending cleared", pending, 8'h00);
    check("R9 masked cleared", masked, 8'h00);
    check("R9 trig kept", trig_mode, 8'hF0);
    cyc(8'h01, 8'h01, 8'h00);
    check("R9 relatch after init", pending, 8'h01);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule